// File: doc/BRIEF.md
# Synchronous card clock start/stop sequencer

This block drives the clock and data lines of a two-wire synchronous smart-card link. It generates the card clock from a programmable half-ETU divider. A bit-length counter tracks the bits clocked across the link. On request, the block builds a start or a stop condition: it freezes the card clock high, moves the data line by hand, switches the transfer direction and reloads the counter. It then lets the clock run again.

The data line is open-drain. The block only ever pulls it low, through `io_oe`. It reads the pad back through a synchronizer to collect received bits. A start condition loads one transmit byte, which goes out most significant bit first. A stop condition turns the link around so that the card can send a byte. In acknowledge mode, the block pulls the line low in the ninth slot of a received byte.

Top module: `clkss_seq`

## Requirements
- R1: After reset `card_clk` is held high, `io_oe` is 0, and `busy`, `irq`, `rx_valid` and `start_err` are 0.
- R2: While not held, `card_clk` spends `half_div`+1 system clocks in each phase, so one full period is 2*(`half_div`+1) clocks.
- R3: The bit counter advances on each falling `card_clk` edge. It sets `irq` when it reaches DATA_W+1 (its maximum). `irq` stays set until `irq_clr`, and the reload done by a sequence does not set it.
- R4: A start sequence leaves `busy` with `card_clk` high and the data line low (start bit). The falling data edge happens while the clock is held high.
- R5: A `start_req` while `tx_valid` is 0 and the block is idle launches nothing. Instead it gives a one-cycle `start_err` pulse in the following cycle.
- R6: After a start, slots 1..DATA_W (the slot number rises on each falling clock edge) carry `tx_data`, MSB first, on the line. Line level = not `io_oe` when the card does not pull low. `tx_take` pulses once when the byte is latched.
- R7: A stop sequence raises the data line while the clock is held high, then selects receive mode. It ends with the line high and `card_clk` high.
- R8: At least one half ETU (`half_div`+1 clocks) separates the last data-line change of a sequence from the clock release, which is the falling edge of `busy`.
- R9: In receive mode, the block samples the line on the rising clock edges of slots 1..DATA_W, MSB first. When the counter reaches its maximum, it pulses `rx_valid` with the byte on `rx_data`.
- R10: In receive mode, slot DATA_W+1 (the acknowledge slot) has `io_oe` = `i2c_mode`.
- R11: `busy` is high from request acceptance until clock release. `start_req` and `stop_req` arriving while busy are ignored: no extra `tx_take` or `start_err`, and the running sequence keeps its kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | HALF_W | Half-ETU length minus one, in system clocks |
| i2c_mode | input | 1 | Drive acknowledge low in receive slot DATA_W+1 |
| tx_data | input | DATA_W | Byte to send after a start |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_take | output | 1 | One-cycle pulse: byte latched |
| start_req | input | 1 | Request a start condition |
| stop_req | input | 1 | Request a stop condition |
| irq_clr | input | 1 | Clear the counter-max flag |
| io_pad_i | input | 1 | Data pad read-back |
| card_clk | output | 1 | Card clock |
| io_oe | output | 1 | Pull data line low |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` new |
| busy | output | 1 | Sequence in progress |
| irq | output | 1 | Counter reached maximum (sticky) |
| start_err | output | 1 | Start refused: no transmit data |

## Verification
The assertions assume that `tx_valid` and `tx_data` stay stable from an accepted start until `tx_take`. They also assume that `half_div` does not change during a run, so that the half-ETU separation is measured against a fixed length. Finally, they assume that the card moves the line only on falling clock edges, at least two system clocks before the next rising edge.

The stimulus holds the transmit byte for the whole vector and fixes the divider at 3. The modelled card changes its pull-down one clock after it sees a falling edge, which leaves the synchronizer a full half ETU before sampling.

// File: rtl/clkss_pkg.sv
package clkss_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_WAIT,
      SQ_S1,
      SQ_S2,
      SQ_S3,
      SQ_S4
   } sq_state_t;

endpackage

// File: rtl/clkss_tick.sv
module clkss_tick #(
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_W-1:0] half_div,
   output logic              tick
);

   logic [HALF_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         tick  <= 1'b0;
      end else if (div_q >= half_div) begin
         div_q <= '0;
         tick  <= 1'b1;
      end else begin
         div_q <= div_q + 1'b1;
         tick  <= 1'b0;
      end
   end

endmodule

// File: rtl/clkss_bitcnt.sv
module clkss_bitcnt #(
   parameter int LEN   = 9,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             at_max,
   output logic             at_zero,
   output logic             hit,
   output logic             irq
);

   localparam logic [CNT_W-1:0] MAXV = CNT_W'(LEN);

   assign at_max  = (cnt == MAXV);
   assign at_zero = (cnt == '0);
   assign hit     = step && (cnt == MAXV - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= MAXV;
      else if (load)             cnt <= '0;
      else if (step && !at_max)  cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq <= 1'b0;
      else if (hit)     irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
   end

endmodule

// File: rtl/clkss_pad.sv
module clkss_pad #(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              tx_mode,
   input  logic              io_bit,
   input  logic              i2c_mode,
   input  logic              at_zero,
   input  logic              at_max,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [DATA_W-1:0] tx_sh,
   input  logic              io_pad_i,
   output logic              io_oe,
   output logic              io_s
);

   logic [CNT_W-1:0] slot_m1;
   logic             data_bit;

   assign slot_m1 = cnt - 1'b1;

   generate
      if (MSB_FIRST) begin : g_msb
         logic [DATA_W-1:0] shl;
         assign shl      = tx_sh << slot_m1;
         assign data_bit = shl[DATA_W-1];
      end else begin : g_lsb
         logic [DATA_W-1:0] shr;
         assign shr      = tx_sh >> slot_m1;
         assign data_bit = shr[0];
      end
   endgenerate

   always_comb begin
      if (hold || (tx_mode && (at_zero || at_max))) io_oe = !io_bit;
      else if (tx_mode)                             io_oe = !data_bit;
      else                                          io_oe = i2c_mode && at_max;
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], io_pad_i};
   end

   assign io_s = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/clkss_seq.sv
module clkss_seq
   import clkss_pkg::*;
#(
   parameter int HALF_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_W-1:0] half_div,
   input  logic              i2c_mode,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_take,
   input  logic              start_req,
   input  logic              stop_req,
   input  logic              irq_clr,
   input  logic              io_pad_i,
   output logic              card_clk,
   output logic              io_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              busy,
   output logic              irq,
   output logic              start_err
);

   localparam int LEN   = DATA_W + 1;
   localparam int CNT_W = $clog2(LEN + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("clkss_seq: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkss_seq: SYNC_STAGES must be at least 2");
      end
      if (HALF_W < 1) begin : g_bad_div
         $error("clkss_seq: HALF_W must be at least 1");
      end
   endgenerate

   logic              tick;
   sq_state_t         state_q;
   logic              hold_q, card_clk_q, tx_mode_q, io_bit_q, op_stop_q;
   logic              freeze, fall, rise, load;
   logic [CNT_W-1:0]  cnt;
   logic              at_max, at_zero, hit, io_s;
   logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_next;

   clkss_tick #(.HALF_W(HALF_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .half_div (half_div),
      .tick     (tick)
   );

   assign freeze = tick && (state_q == SQ_WAIT) && at_max && card_clk_q;
   assign fall   = tick && !hold_q && card_clk_q && !freeze;
   assign rise   = tick && !hold_q && !card_clk_q;
   assign load   = tick && (((state_q == SQ_S2) && !op_stop_q) ||
                            ((state_q == SQ_S3) && op_stop_q));

   clkss_bitcnt #(.LEN(LEN), .CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (fall),
      .irq_clr (irq_clr),
      .cnt     (cnt),
      .at_max  (at_max),
      .at_zero (at_zero),
      .hit     (hit),
      .irq     (irq)
   );

   clkss_pad #(
      .DATA_W      (DATA_W),
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES),
      .MSB_FIRST   (MSB_FIRST)
   ) u_pad (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold_q),
      .tx_mode  (tx_mode_q),
      .io_bit   (io_bit_q),
      .i2c_mode (i2c_mode),
      .at_zero  (at_zero),
      .at_max   (at_max),
      .cnt      (cnt),
      .tx_sh    (tx_sh_q),
      .io_pad_i (io_pad_i),
      .io_oe    (io_oe),
      .io_s     (io_s)
   );

   // card clock: toggles on half-ETU ticks unless frozen high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    card_clk_q <= 1'b1;
      else if (fall) card_clk_q <= 1'b0;
      else if (rise) card_clk_q <= 1'b1;
   end

   assign card_clk = card_clk_q;
   assign busy     = (state_q != SQ_IDLE);

   // start/stop sequencer, one step per half ETU once the clock is frozen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         hold_q    <= 1'b1;
         tx_mode_q <= 1'b0;
         io_bit_q  <= 1'b1;
         op_stop_q <= 1'b0;
         tx_sh_q   <= '0;
         tx_take   <= 1'b0;
         start_err <= 1'b0;
      end else begin
         tx_take   <= 1'b0;
         start_err <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (start_req) begin
                  if (tx_valid) begin
                     op_stop_q <= 1'b0;
                     state_q   <= SQ_WAIT;
                  end else begin
                     start_err <= 1'b1;
                  end
               end else if (stop_req) begin
                  op_stop_q <= 1'b1;
                  state_q   <= SQ_WAIT;
               end
            end
            SQ_WAIT: if (freeze) begin
               hold_q <= 1'b1;
               if (op_stop_q) io_bit_q <= 1'b0;
               state_q <= SQ_S1;
            end
            SQ_S1: if (tick) begin
               if (op_stop_q) io_bit_q  <= 1'b1;
               else           tx_mode_q <= 1'b1;
               state_q <= SQ_S2;
            end
            SQ_S2: if (tick) begin
               if (op_stop_q) begin
                  tx_mode_q <= 1'b0;
               end else begin
                  tx_sh_q <= tx_data;
                  tx_take <= 1'b1;
               end
               state_q <= SQ_S3;
            end
            SQ_S3: if (tick) begin
               if (!op_stop_q) io_bit_q <= 1'b0;
               state_q <= SQ_S4;
            end
            SQ_S4: if (tick) begin
               hold_q  <= 1'b0;
               state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   generate
      if (MSB_FIRST) begin : g_rx_msb
         assign rx_next = {rx_sh_q[DATA_W-2:0], io_s};
      end else begin : g_rx_lsb
         assign rx_next = {io_s, rx_sh_q[DATA_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh_q  <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (rise && !tx_mode_q && !at_zero && !at_max) rx_sh_q <= rx_next;
         if (hit && !tx_mode_q) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_sh_q;
         end
      end
   end

endmodule

// File: rtl/clkss_chk.sv
module clkss_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic start_req,
   input logic tx_valid,
   input logic start_err,
   input logic irq,
   input logic irq_clr,
   input logic hold,
   input logic card_clk,
   input logic rx_valid,
   input logic tx_mode,
   input logic op_stop
);

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_clr |=> irq); // R3

   AST_HOLD_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> card_clk); // R4

   AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      start_req && !tx_valid && !busy |=> !busy && start_err); // R5

   AST_RXV_IN_RX_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !tx_mode); // R9

   AST_BUSY_KEEPS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(op_stop))); // R11

   AST_ERR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_err |-> !busy); // R5

endmodule

bind clkss_seq clkss_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .start_req (start_req),
   .tx_valid  (tx_valid),
   .start_err (start_err),
   .irq       (irq),
   .irq_clr   (irq_clr),
   .hold      (hold_q),
   .card_clk  (card_clk),
   .rx_valid  (rx_valid),
   .tx_mode   (tx_mode_q),
   .op_stop   (op_stop_q)
);

// File: tb/sim_clkss_seq.sv
module sim_clkss_seq;
   localparam int HALF_W = 8;
   localparam int DATA_W = 8;
   localparam logic [HALF_W-1:0] HDIV = 8'd3;
   localparam int HETU = 4;
   localparam int NV = 4;
   // {i2c_mode, tx byte, byte the card returns}
   localparam logic [16:0] VECS [NV] = '{
      {1'b0, 8'hA5, 8'h3C},
      {1'b1, 8'hFF, 8'h00},
      {1'b1, 8'h00, 8'hFF},
      {1'b0, 8'h81, 8'h7E}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic i2c_mode = 1'b0, tx_valid = 1'b0, start_req = 1'b0, stop_req = 1'b0;
   logic irq_clr = 1'b0, card_low = 1'b0;
   logic [DATA_W-1:0] tx_data = '0;
   logic tx_take, card_clk, io_oe, rx_valid, busy, irq, start_err, pad;
   logic [DATA_W-1:0] rx_data;

   assign pad = !(io_oe || card_low);

   always #10 clk = ~clk;

   clkss_seq #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .half_div(HDIV), .i2c_mode(i2c_mode),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take),
      .start_req(start_req), .stop_req(stop_req), .irq_clr(irq_clr),
      .io_pad_i(pad), .card_clk(card_clk), .io_oe(io_oe), .rx_data(rx_data),
      .rx_valid(rx_valid), .busy(busy), .irq(irq), .start_err(start_err)
   );

   int nvec = 0, nerr = 0, cyc = 0, last_chg = 0, n_take = 0, n_serr = 0;
   logic [DATA_W-1:0] rx_got = '0;
   logic p_pad = 1'b1, p_busy = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // line monitor: edges during a sequence and release spacing
   always @(negedge clk) begin
      cyc++;
      if (rx_valid) rx_got = rx_data;
      if (tx_take) n_take++;
      if (start_err) n_serr++;
      if (rst_n && busy && (pad != p_pad))
         chk(card_clk == 1'b1, "R4/R7 line edge with clock held high", card_clk, 1);
      if (pad != p_pad) last_chg = cyc;
      if (rst_n && p_busy && !busy)
         chk(cyc - last_chg >= HETU, "R8 half ETU before release", cyc - last_chg, HETU);
      p_pad  = pad;
      p_busy = busy;
      if (cyc == 150000) begin
         chk(1'b0, "watchdog", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_rise();
      logic p;
      @(negedge clk); p = card_clk;
      forever begin
         @(negedge clk);
         if (!p && card_clk) break;
         p = card_clk;
      end
   endtask

   task automatic wait_fall();
      logic p;
      @(negedge clk); p = card_clk;
      forever begin
         @(negedge clk);
         if (p && !card_clk) break;
         p = card_clk;
      end
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic pulse_start();
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
   endtask

   task automatic pulse_stop();
      stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
   endtask

   initial begin
      logic [16:0] vec;
      logic [DATA_W-1:0] got;
      int t0;
      int take0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
      // R1 reset state
      chk(card_clk == 1'b1 && io_oe == 1'b0, "R1 clock high, line released", {card_clk, io_oe}, 2'b10);
      chk(!busy && !irq && !rx_valid && !start_err, "R1 status clear",
          {busy, irq, rx_valid, start_err}, 0);

      // R5 start without data
      tx_valid = 1'b0;
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
      chk(start_err == 1'b1 && busy == 1'b0, "R5 start refused", {start_err, busy}, 2'b10);
      @(negedge clk);
      chk(start_err == 1'b0 && busy == 1'b0, "R5 error is one pulse", {start_err, busy}, 0);

      for (int v = 0; v < NV; v++) begin
         vec = VECS[v];
         i2c_mode = vec[16];
         tx_data  = vec[15:8];
         tx_valid = 1'b1;
         take0 = n_take;
         pulse_start();
         @(negedge clk);
         pulse_stop();                       // R11 ignored while busy
         wait_idle();
         chk(pad == 1'b0 && card_clk == 1'b1, "R4 start bit low under high clock", {pad, card_clk}, 2'b01);
         chk(irq == 1'b0, "R3 reload leaves irq clear", irq, 0);
         chk(n_take == take0 + 1, "R6 byte taken once", n_take - take0, 1);
         got = '0;
         t0 = 0;
         for (int k = 0; k < DATA_W; k++) begin
            wait_rise();
            if (k == 0) t0 = cyc;
            if (k == 1) chk(cyc - t0 == 2 * HETU, "R2 clock period", cyc - t0, 2 * HETU);
            got = {got[DATA_W-2:0], pad};
         end
         chk(got == vec[15:8], "R6 transmitted byte", got, vec[15:8]);
         chk(irq == 1'b0, "R3 no irq before max", irq, 0);
         wait_fall();
         wait_cyc(3);
         chk(irq == 1'b1, "R3 irq at max and sticky", irq, 1);
         irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
         chk(irq == 1'b0, "R3 irq cleared", irq, 0);

         tx_valid = 1'b0;
         take0 = n_take;
         pulse_stop();
         @(negedge clk);
         pulse_start();                      // R11 ignored while busy
         wait_idle();
         chk(pad == 1'b1 && card_clk == 1'b1, "R7 stop leaves line high", {pad, card_clk}, 2'b11);
         chk(n_take == take0, "R11 no byte taken by ignored start", n_take - take0, 0);
         for (int f = 1; f <= DATA_W; f++) begin
            wait_fall();
            card_low = !vec[DATA_W - f];
         end
         wait_fall();
         card_low = 1'b0;
         wait_cyc(2);
         chk(rx_got == vec[7:0], "R9 received byte", rx_got, vec[7:0]);
         chk(irq == 1'b1, "R3 irq after receive", irq, 1);
         wait_rise();
         chk(io_oe == vec[16], "R10 acknowledge slot drive", io_oe, vec[16]);
         irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
      end
      chk(n_serr == 1, "R5 R11 error pulses", n_serr, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule